// File: doc/BRIEF.md
# TLB Entry Maintenance Controller

This block carries out the three maintenance operations that software uses on a translation buffer: writing an entry at a given slot, filling an entry into a slot the hardware picks, and reading a slot back. It does no associative lookup and raises no exceptions. It takes its operands from two banks of staging registers, supplied as input ports. A refill flag picks the bank: one bank serves ordinary software use and the other serves a refill handler. The block drives a single write port of the entry array and returns read results as updated staging values.

The array has two partitions. The lower partition is set-indexed. It holds 8 ways of 256 sets, and every entry in it shares one page size. The upper partition holds 64 entries, and each of those stores its own page size. A fill whose page size equals the shared size goes to the lower partition. There, the set comes from the virtual page number and the way comes from a free-running 16-bit LFSR. Any other page size goes to a random slot in the upper partition. A page size is accepted only when its bit is set in a 64-bit support mask. A write or fill with an unsupported size leaves the array untouched.

Top module: `tlbm_ctrl`

## Requirements
- R1: After reset, `arr_we`, `arr_ps_we`, `arr_clr` and `rd_done` are all 0.
- R2: When `refill_mode` is 1, the page size, page number and both low words come from the `rfl_*` inputs. When it is 0, they come from the `nrm_*` inputs. Slot index and not-exist bit always come from `nrm_index` and `nrm_ne`.
- R3: A write (`op_kind` 2'b01, `nrm_ne`=0) or a fill (2'b10) whose selected page size has its bit clear in `ps_mask` produces no array write and no clear.
- R4: A write with `nrm_ne`=0 and a legal size pulses `arr_we` at `nrm_index`. It presents the page number, `asid`, both low words and the size. `arr_ps_we` is 1 only when the index is 2048 or above.
- R5: A write with `nrm_ne`=1 pulses only `arr_clr` at `nrm_index`, which clears the valid bit of that slot. This happens whatever the page size.
- R6: A fill whose legal size equals a legal `fix_ps` writes slot way*256+set, with way 0..7. The set is bits [ps+8:ps+1] of the byte address formed by placing the page number above 13 zero bits. `arr_ps_we` is 0.
- R7: A fill aborts with no array write when `fix_ps` is illegal, even if the entry's own size is legal.
- R8: A fill with a legal size different from `fix_ps` writes a slot in 2048..2111 with `arr_ps_we`=1.
- R9: A read (`op_kind` 2'b11) of a slot whose valid bit is 0 returns `rd_ne`=1 and `rd_asid_zero`=1, with size, page number and both low words all zero.
- R10: A read of a valid slot returns `rd_ne`=0, its page number and low words, and its size. The size is the stored one at 2048 and above, and `fix_ps` below 2048.
- R11: Every result appears in the cycle after the strobe, and every strobe output is a one-cycle pulse.
- R12: Repeated fills into the lower partition spread over more than one way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_kind | input | 2 | 01 write, 10 fill, 11 read, 00 none |
| refill_mode | input | 1 | Selects the refill staging bank |
| asid | input | 10 | Current address-space id |
| ps_mask | input | 64 | Supported page-size mask |
| fix_ps | input | 6 | Shared page size of the lower partition |
| nrm_index | input | 12 | Slot index for write and read |
| nrm_ne | input | 1 | Not-exist bit of the index register |
| nrm_ps | input | 6 | Normal-bank page size |
| nrm_vppn | input | 35 | Normal-bank virtual page-pair number |
| nrm_lo0 | input | 32 | Normal-bank even low word |
| nrm_lo1 | input | 32 | Normal-bank odd low word |
| rfl_ps | input | 6 | Refill-bank page size |
| rfl_vppn | input | 35 | Refill-bank virtual page-pair number |
| rfl_lo0 | input | 32 | Refill-bank even low word |
| rfl_lo1 | input | 32 | Refill-bank odd low word |
| arr_rd_idx | output | 12 | Array read address |
| arr_rd_e | input | 1 | Valid bit of the addressed slot |
| arr_rd_vppn | input | 35 | Page number of the addressed slot |
| arr_rd_ps | input | 6 | Stored page size of the addressed slot |
| arr_rd_lo0 | input | 32 | Even low word of the addressed slot |
| arr_rd_lo1 | input | 32 | Odd low word of the addressed slot |
| arr_we | output | 1 | Full entry write strobe (sets valid) |
| arr_ps_we | output | 1 | Page-size field write strobe |
| arr_clr | output | 1 | Clear-valid strobe |
| arr_idx | output | 12 | Array write address |
| arr_vppn | output | 35 | Page number to write |
| arr_asid | output | 10 | ASID to write |
| arr_ps | output | 6 | Page size to write |
| arr_lo0 | output | 32 | Even low word to write |
| arr_lo1 | output | 32 | Odd low word to write |
| rd_done | output | 1 | Read result strobe |
| rd_ne | output | 1 | Read result not-exist bit |
| rd_ps | output | 6 | Read result page size |
| rd_vppn | output | 35 | Read result page number |
| rd_lo0 | output | 32 | Read result even low word |
| rd_lo1 | output | 32 | Read result odd low word |
| rd_asid_zero | output | 1 | The ASID register must be zeroed |

## Verification
The assertions assume three things about the inputs. `nrm_index` stays below 2112. The array read ports return the contents of `arr_rd_idx` in the same cycle. No operation is issued in the cycle when a previous result is being written back. The stimulus respects all three. It draws indices only from slots inside both partitions, models the array as a register file updated on the write strobes, and leaves one idle cycle after each operation. The page sizes are drawn from a short list that mixes supported and unsupported values, and the shared size is sometimes made illegal, so every abort path is reached.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;

    localparam int unsigned PS_W      = 6;
    localparam int unsigned MASK_W    = 1 << PS_W;
    localparam int unsigned PG_OFF_W  = 13;
    localparam int unsigned RND_W     = 16;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_FILL  = 2'b10,
        OP_READ  = 2'b11
    } op_e;

    function automatic logic ps_ok(input logic [PS_W-1:0] ps,
                                   input logic [MASK_W-1:0] mask);
        return mask[ps];
    endfunction

endpackage

// File: rtl/tlbm_lfsr.sv
module tlbm_lfsr #(
    parameter int unsigned         W    = 16,
    parameter logic [W-1:0]        SEED = 16'hACE1,
    parameter logic [W-1:0]        TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] rnd
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rnd <= SEED;
        end else begin
            rnd <= {1'b0, rnd[W-1:1]} ^ (rnd[0] ? TAPS : '0);
        end
    end

    // R12: a zero state would freeze the way choice
    assert_lfsr_nonzero_R12: assert property (@(posedge clk) disable iff (rst)
        rnd != '0);

endmodule

// File: rtl/tlbm_stage_mux.sv
module tlbm_stage_mux
    import tlbm_pkg::*;
#(
    parameter int unsigned VPPN_W = 35,
    parameter int unsigned LO_W   = 32
) (
    input  logic              refill_mode,
    input  logic [PS_W-1:0]   nrm_ps,
    input  logic [VPPN_W-1:0] nrm_vppn,
    input  logic [LO_W-1:0]   nrm_lo0,
    input  logic [LO_W-1:0]   nrm_lo1,
    input  logic [PS_W-1:0]   rfl_ps,
    input  logic [VPPN_W-1:0] rfl_vppn,
    input  logic [LO_W-1:0]   rfl_lo0,
    input  logic [LO_W-1:0]   rfl_lo1,
    output logic [PS_W-1:0]   sel_ps,
    output logic [VPPN_W-1:0] sel_vppn,
    output logic [LO_W-1:0]   sel_lo0,
    output logic [LO_W-1:0]   sel_lo1
);

    always_comb begin
        if (refill_mode) begin
            sel_ps   = rfl_ps;
            sel_vppn = rfl_vppn;
            sel_lo0  = rfl_lo0;
            sel_lo1  = rfl_lo1;
        end else begin
            sel_ps   = nrm_ps;
            sel_vppn = nrm_vppn;
            sel_lo0  = nrm_lo0;
            sel_lo1  = nrm_lo1;
        end
    end

endmodule

// File: rtl/tlbm_fill_place.sv
module tlbm_fill_place
    import tlbm_pkg::*;
#(
    parameter int unsigned VPPN_W   = 35,
    parameter int unsigned FIX_WAYS = 8,
    parameter int unsigned FIX_SETS = 256,
    parameter int unsigned VAR_N    = 64,
    parameter int unsigned IDX_W    = 12
) (
    input  logic [VPPN_W-1:0] vppn,
    input  logic [PS_W-1:0]   ps,
    input  logic [PS_W-1:0]   fix_ps,
    input  logic [RND_W-1:0]  rnd,
    output logic              to_fix,
    output logic [IDX_W-1:0]  idx
);

    localparam int unsigned ADDR_W    = VPPN_W + PG_OFF_W;
    localparam int unsigned WAY_W     = (FIX_WAYS > 1) ? $clog2(FIX_WAYS) : 1;
    localparam int unsigned SET_W     = (FIX_SETS > 1) ? $clog2(FIX_SETS) : 1;
    localparam int unsigned VAR_W     = (VAR_N > 1) ? $clog2(VAR_N) : 1;
    localparam int unsigned FIX_TOTAL = FIX_WAYS * FIX_SETS;
    localparam logic [IDX_W-1:0] VAR_BASE = IDX_W'(FIX_TOTAL);

    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] shifted;
    logic [SET_W-1:0]  set_sel;
    logic [WAY_W-1:0]  way_sel;
    logic [VAR_W-1:0]  var_off;

    assign addr    = {vppn, {PG_OFF_W{1'b0}}};
    assign shifted = addr >> ({1'b0, ps} + 7'd1);
    assign set_sel = shifted[SET_W-1:0];

    // Power-of-two partitions take random bits by masking, others by modulo
    generate
        if ((FIX_WAYS & (FIX_WAYS - 1)) == 0) begin : g_way_mask
            assign way_sel = rnd[WAY_W-1:0];
        end else begin : g_way_mod
            assign way_sel = WAY_W'(rnd % RND_W'(FIX_WAYS));
        end
        if ((VAR_N & (VAR_N - 1)) == 0) begin : g_var_mask
            assign var_off = rnd[RND_W-1 -: VAR_W];
        end else begin : g_var_mod
            assign var_off = VAR_W'(rnd % RND_W'(VAR_N));
        end
    endgenerate

    always_comb begin
        to_fix = (ps == fix_ps);
        if (to_fix) begin
            idx = IDX_W'(way_sel) * IDX_W'(FIX_SETS) + IDX_W'(set_sel);
        end else begin
            idx = VAR_BASE + IDX_W'(var_off);
        end
    end

endmodule

// File: rtl/tlbm_ctrl.sv
module tlbm_ctrl
    import tlbm_pkg::*;
#(
    parameter int unsigned VPPN_W   = 35,
    parameter int unsigned LO_W     = 32,
    parameter int unsigned ASID_W   = 10,
    parameter int unsigned FIX_WAYS = 8,
    parameter int unsigned FIX_SETS = 256,
    parameter int unsigned VAR_N    = 64,
    parameter int unsigned IDX_W    = $clog2(FIX_WAYS * FIX_SETS + VAR_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic              refill_mode,
    input  logic [ASID_W-1:0] asid,
    input  logic [63:0]       ps_mask,
    input  logic [5:0]        fix_ps,
    input  logic [IDX_W-1:0]  nrm_index,
    input  logic              nrm_ne,
    input  logic [5:0]        nrm_ps,
    input  logic [VPPN_W-1:0] nrm_vppn,
    input  logic [LO_W-1:0]   nrm_lo0,
    input  logic [LO_W-1:0]   nrm_lo1,
    input  logic [5:0]        rfl_ps,
    input  logic [VPPN_W-1:0] rfl_vppn,
    input  logic [LO_W-1:0]   rfl_lo0,
    input  logic [LO_W-1:0]   rfl_lo1,
    output logic [IDX_W-1:0]  arr_rd_idx,
    input  logic              arr_rd_e,
    input  logic [VPPN_W-1:0] arr_rd_vppn,
    input  logic [5:0]        arr_rd_ps,
    input  logic [LO_W-1:0]   arr_rd_lo0,
    input  logic [LO_W-1:0]   arr_rd_lo1,
    output logic              arr_we,
    output logic              arr_ps_we,
    output logic              arr_clr,
    output logic [IDX_W-1:0]  arr_idx,
    output logic [VPPN_W-1:0] arr_vppn,
    output logic [ASID_W-1:0] arr_asid,
    output logic [5:0]        arr_ps,
    output logic [LO_W-1:0]   arr_lo0,
    output logic [LO_W-1:0]   arr_lo1,
    output logic              rd_done,
    output logic              rd_ne,
    output logic [5:0]        rd_ps,
    output logic [VPPN_W-1:0] rd_vppn,
    output logic [LO_W-1:0]   rd_lo0,
    output logic [LO_W-1:0]   rd_lo1,
    output logic              rd_asid_zero
);

    localparam int unsigned FIX_TOTAL = FIX_WAYS * FIX_SETS;
    localparam int unsigned TOTAL     = FIX_TOTAL + VAR_N;
    localparam logic [IDX_W-1:0] VAR_BASE = IDX_W'(FIX_TOTAL);
    localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(TOTAL);

    op_e               op;
    logic [PS_W-1:0]   sel_ps;
    logic [VPPN_W-1:0] sel_vppn;
    logic [LO_W-1:0]   sel_lo0;
    logic [LO_W-1:0]   sel_lo1;
    logic [RND_W-1:0]  rnd;
    logic              fill_to_fix;
    logic [IDX_W-1:0]  fill_idx;
    logic              sel_legal;
    logic              fix_legal;
    logic              idx_in_var;

    assign op         = op_e'(op_kind);
    assign arr_rd_idx = nrm_index;
    assign sel_legal  = ps_ok(sel_ps, ps_mask);
    assign fix_legal  = ps_ok(fix_ps, ps_mask);
    assign idx_in_var = (nrm_index >= VAR_BASE);

    tlbm_stage_mux #(.VPPN_W(VPPN_W), .LO_W(LO_W)) i_mux (
        .refill_mode (refill_mode),
        .nrm_ps      (nrm_ps),
        .nrm_vppn    (nrm_vppn),
        .nrm_lo0     (nrm_lo0),
        .nrm_lo1     (nrm_lo1),
        .rfl_ps      (rfl_ps),
        .rfl_vppn    (rfl_vppn),
        .rfl_lo0     (rfl_lo0),
        .rfl_lo1     (rfl_lo1),
        .sel_ps      (sel_ps),
        .sel_vppn    (sel_vppn),
        .sel_lo0     (sel_lo0),
        .sel_lo1     (sel_lo1)
    );

    tlbm_lfsr #(.W(RND_W)) i_lfsr (
        .clk (clk),
        .rst (rst),
        .rnd (rnd)
    );

    tlbm_fill_place #(
        .VPPN_W   (VPPN_W),
        .FIX_WAYS (FIX_WAYS),
        .FIX_SETS (FIX_SETS),
        .VAR_N    (VAR_N),
        .IDX_W    (IDX_W)
    ) i_place (
        .vppn   (sel_vppn),
        .ps     (sel_ps),
        .fix_ps (fix_ps),
        .rnd    (rnd),
        .to_fix (fill_to_fix),
        .idx    (fill_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            arr_we       <= 1'b0;
            arr_ps_we    <= 1'b0;
            arr_clr      <= 1'b0;
            arr_idx      <= '0;
            arr_vppn     <= '0;
            arr_asid     <= '0;
            arr_ps       <= '0;
            arr_lo0      <= '0;
            arr_lo1      <= '0;
            rd_done      <= 1'b0;
            rd_ne        <= 1'b0;
            rd_ps        <= '0;
            rd_vppn      <= '0;
            rd_lo0       <= '0;
            rd_lo1       <= '0;
            rd_asid_zero <= 1'b0;
        end else begin
            arr_we    <= 1'b0;
            arr_ps_we <= 1'b0;
            arr_clr   <= 1'b0;
            rd_done   <= 1'b0;
            if (op_valid) begin
                unique case (op)
                    OP_WRITE: begin
                        arr_idx <= nrm_index;
                        if (nrm_ne) begin
                            arr_clr <= 1'b1;
                        end else if (sel_legal) begin
                            arr_we    <= 1'b1;
                            arr_ps_we <= idx_in_var;
                            arr_vppn  <= sel_vppn;
                            arr_asid  <= asid;
                            arr_ps    <= sel_ps;
                            arr_lo0   <= sel_lo0;
                            arr_lo1   <= sel_lo1;
                        end
                    end
                    OP_FILL: begin
                        if (sel_legal && fix_legal) begin
                            arr_we    <= 1'b1;
                            arr_ps_we <= !fill_to_fix;
                            arr_idx   <= fill_idx;
                            arr_vppn  <= sel_vppn;
                            arr_asid  <= asid;
                            arr_ps    <= sel_ps;
                            arr_lo0   <= sel_lo0;
                            arr_lo1   <= sel_lo1;
                        end
                    end
                    OP_READ: begin
                        rd_done <= 1'b1;
                        if (!arr_rd_e) begin
                            rd_ne        <= 1'b1;
                            rd_asid_zero <= 1'b1;
                            rd_ps        <= '0;
                            rd_vppn      <= '0;
                            rd_lo0       <= '0;
                            rd_lo1       <= '0;
                        end else begin
                            rd_ne        <= 1'b0;
                            rd_asid_zero <= 1'b0;
                            rd_ps        <= idx_in_var ? arr_rd_ps : fix_ps;
                            rd_vppn      <= arr_rd_vppn;
                            rd_lo0       <= arr_rd_lo0;
                            rd_lo1       <= arr_rd_lo1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_clr_source_R5: assert property (@(posedge clk) disable iff (rst)
        arr_clr |-> $past(op_valid && op_kind == 2'b01 && nrm_ne));

    assert_bad_ps_abort_R3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && ((op_kind == 2'b01 && !nrm_ne) || op_kind == 2'b10)
         && !ps_mask[sel_ps]) |=> (!arr_we && !arr_clr));

    assert_fix_abort_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'b10 && !ps_mask[fix_ps]) |=> !arr_we);

    assert_fix_slot_R6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'b10 && sel_ps == fix_ps)
        |=> (!arr_we || (arr_idx < VAR_BASE && !arr_ps_we)));

    assert_var_slot_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'b10 && sel_ps != fix_ps)
        |=> (!arr_we || (arr_idx >= VAR_BASE && arr_idx < IDX_END && arr_ps_we)));

    assert_read_ne_R9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'b11) |=> (rd_done && rd_ne == !$past(arr_rd_e)));

    assert_we_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        (arr_we || arr_clr || rd_done) |-> $past(op_valid));

endmodule

// File: tb/test_tlbm_ctrl.sv
module test_tlbm_ctrl;

    localparam int TOT = 2112;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic        refill_mode = 1'b0;
    logic [9:0]  asid = '0;
    logic [63:0] ps_mask = '0;
    logic [5:0]  fix_ps = '0;
    logic [11:0] nrm_index = '0;
    logic        nrm_ne = 1'b0;
    logic [5:0]  nrm_ps = '0, rfl_ps = '0;
    logic [34:0] nrm_vppn = '0, rfl_vppn = '0;
    logic [31:0] nrm_lo0 = '0, nrm_lo1 = '0, rfl_lo0 = '0, rfl_lo1 = '0;
    logic [11:0] arr_rd_idx;
    logic        arr_rd_e;
    logic [34:0] arr_rd_vppn;
    logic [5:0]  arr_rd_ps;
    logic [31:0] arr_rd_lo0, arr_rd_lo1;
    logic        arr_we, arr_ps_we, arr_clr;
    logic [11:0] arr_idx;
    logic [34:0] arr_vppn;
    logic [9:0]  arr_asid;
    logic [5:0]  arr_ps;
    logic [31:0] arr_lo0, arr_lo1;
    logic        rd_done, rd_ne, rd_asid_zero;
    logic [5:0]  rd_ps;
    logic [34:0] rd_vppn;
    logic [31:0] rd_lo0, rd_lo1;

    logic        m_e    [TOT];
    logic [34:0] m_vppn [TOT];
    logic [9:0]  m_asid [TOT];
    logic [5:0]  m_ps   [TOT];
    logic [31:0] m_lo0  [TOT];
    logic [31:0] m_lo1  [TOT];

    int n_chk = 0;
    int n_err = 0;
    int unsigned ways_seen = 0;

    always #5 clk = ~clk;

    tlbm_ctrl i_tlbm_ctrl (.*);

    // bench-side entry array, written on the block's strobes
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TOT; i++) m_e[i] <= 1'b0;
        end else if (arr_clr) begin
            m_e[arr_idx] <= 1'b0;
        end else if (arr_we) begin
            m_e[arr_idx]    <= 1'b1;
            m_vppn[arr_idx] <= arr_vppn;
            m_asid[arr_idx] <= arr_asid;
            m_lo0[arr_idx]  <= arr_lo0;
            m_lo1[arr_idx]  <= arr_lo1;
            if (arr_ps_we) m_ps[arr_idx] <= arr_ps;
        end
    end

    assign arr_rd_e    = m_e[arr_rd_idx];
    assign arr_rd_vppn = m_vppn[arr_rd_idx];
    assign arr_rd_ps   = m_ps[arr_rd_idx];
    assign arr_rd_lo0  = m_lo0[arr_rd_idx];
    assign arr_rd_lo1  = m_lo1[arr_rd_idx];

    task automatic ck(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_set(input logic [34:0] v, input logic [5:0] p);
        logic [47:0] a;
        a = {v, 13'b0};
        return 8'(a >> (p + 1));
    endfunction

    task automatic run_op(input logic [1:0] k);
        logic [5:0]  ps_s;
        logic [34:0] vp_s;
        logic [31:0] l0_s, l1_s;
        logic        legal;
        // R2: bank choice follows the refill flag
        ps_s = refill_mode ? rfl_ps : nrm_ps;
        vp_s = refill_mode ? rfl_vppn : nrm_vppn;
        l0_s = refill_mode ? rfl_lo0 : nrm_lo0;
        l1_s = refill_mode ? rfl_lo1 : nrm_lo1;
        legal = ps_mask[ps_s];
        @(negedge clk);
        op_valid = 1'b1;
        op_kind  = k;
        @(negedge clk);
        op_valid = 1'b0;
        op_kind  = 2'b00;
        if (k == 2'b01) begin
            if (nrm_ne) begin
                ck("R5 clr", {arr_clr, arr_we}, 2'b10);
                ck("R5 idx", arr_idx, nrm_index);
            end else if (legal) begin
                ck("R4 we", {arr_we, arr_clr}, 2'b10);
                ck("R4 idx", arr_idx, nrm_index);
                ck("R2 vppn", arr_vppn, vp_s);
                ck("R2 lo", {arr_lo0, arr_lo1}, {l0_s, l1_s});
                ck("R4 asid", arr_asid, asid);
                ck("R4 ps_we", arr_ps_we, nrm_index >= 12'd2048);
                if (nrm_index >= 12'd2048) ck("R4 ps", arr_ps, ps_s);
            end else begin
                ck("R3 write abort", {arr_we, arr_clr}, 2'b00);
            end
        end else if (k == 2'b10) begin
            if (!legal) begin
                ck("R3 fill abort", {arr_we, arr_clr}, 2'b00);
            end else if (!ps_mask[fix_ps]) begin
                ck("R7 fill abort", {arr_we, arr_clr}, 2'b00);
            end else begin
                ck("R4 fill we", arr_we, 1'b1);
                ck("R2 fill vppn", arr_vppn, vp_s);
                ck("R2 fill lo", {arr_lo0, arr_lo1}, {l0_s, l1_s});
                ck("R4 fill asid", arr_asid, asid);
                if (ps_s == fix_ps) begin
                    ck("R6 part", arr_idx < 12'd2048, 1'b1);
                    ck("R6 set", arr_idx[7:0], exp_set(vp_s, ps_s));
                    ck("R6 ps_we", arr_ps_we, 1'b0);
                    ways_seen |= (32'd1 << arr_idx[10:8]);
                end else begin
                    ck("R8 range", (arr_idx >= 12'd2048) && (arr_idx < 12'd2112), 1'b1);
                    ck("R8 ps", {arr_ps_we, arr_ps}, {1'b1, ps_s});
                end
            end
        end else if (k == 2'b11) begin
            ck("R11 rd_done", rd_done, 1'b1);
            if (!m_e[nrm_index]) begin
                ck("R9 flags", {rd_ne, rd_asid_zero}, 2'b11);
                ck("R9 fields", {rd_ps, rd_vppn, rd_lo0}, '0);
                ck("R9 lo1", rd_lo1, '0);
            end else begin
                ck("R10 flags", {rd_ne, rd_asid_zero}, 2'b00);
                ck("R10 vppn", rd_vppn, m_vppn[nrm_index]);
                ck("R10 lo", {rd_lo0, rd_lo1}, {m_lo0[nrm_index], m_lo1[nrm_index]});
                ck("R10 ps", rd_ps, (nrm_index >= 12'd2048) ? m_ps[nrm_index] : fix_ps);
            end
        end
        @(negedge clk);
        ck("R11 pulse", {arr_we, arr_ps_we, arr_clr, rd_done}, 4'b0000);
    endtask

    function automatic logic [5:0] pick_ps();
        case ($urandom_range(0, 3))
            0: return 6'd12;
            1: return 6'd14;
            2: return 6'd21;
            default: return 6'd13;
        endcase
    endfunction

    task automatic load_ops(input logic [11:0] idx, input logic ne, input logic rf,
                            input logic [5:0] p);
        nrm_index   = idx;
        nrm_ne      = ne;
        refill_mode = rf;
        nrm_ps      = rf ? 6'd13 : p;
        rfl_ps      = rf ? p : 6'd13;
        nrm_vppn    = {$urandom, $urandom};
        rfl_vppn    = {$urandom, $urandom};
        nrm_lo0     = $urandom;
        nrm_lo1     = $urandom;
        rfl_lo0     = $urandom;
        rfl_lo1     = $urandom;
        asid        = 10'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        ps_mask = (64'd1 << 12) | (64'd1 << 14) | (64'd1 << 21);
        fix_ps  = 6'd14;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        ck("R1 reset", {arr_we, arr_ps_we, arr_clr, rd_done}, 4'b0000);

        // empty slot reads back as not-existing
        load_ops(12'd5, 1'b0, 1'b0, 6'd14);
        run_op(2'b11);
        // indexed write in lower partition from the normal bank, read back
        run_op(2'b01);
        run_op(2'b11);
        // upper partition write from the refill bank keeps its own size
        load_ops(12'd2050, 1'b0, 1'b1, 6'd21);
        run_op(2'b01);
        run_op(2'b11);
        // unsupported size leaves the slot as it was
        load_ops(12'd2050, 1'b0, 1'b0, 6'd13);
        run_op(2'b01);
        run_op(2'b11);
        // not-exist write clears the slot whatever the size
        load_ops(12'd5, 1'b1, 1'b0, 6'd13);
        run_op(2'b01);
        nrm_ne = 1'b0;
        run_op(2'b11);
        // illegal shared size aborts a fill
        fix_ps = 6'd13;
        load_ops(12'd0, 1'b0, 1'b0, 6'd12);
        run_op(2'b10);
        fix_ps = 6'd14;
        // fills into both partitions, way spread
        for (int i = 0; i < 16; i++) begin
            load_ops(12'd0, 1'b0, i[0], 6'd14);
            run_op(2'b10);
        end
        load_ops(12'd0, 1'b0, 1'b1, 6'd21);
        run_op(2'b10);
        ck("R12 ways", ($countones(ways_seen) > 1), 1'b1);

        // mixed random traffic
        for (int i = 0; i < 300; i++) begin
            logic [11:0] idx;
            idx = ($urandom_range(0, 1) == 1) ? 12'(($urandom_range(0, 7) << 8) | 3)
                                              : 12'(2048 + $urandom_range(0, 7));
            load_ops(idx, ($urandom_range(0, 5) == 0), 1'($urandom_range(0, 1)), pick_ps());
            fix_ps = ($urandom_range(0, 7) == 0) ? 6'd13 : 6'd14;
            run_op(2'($urandom_range(1, 3)));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule